// File: doc/BRIEF.md
# Control Transfer History Buffer

This block keeps a short, register-held history of control-flow transfers for profiling and debug. Every transfer that reaches it has already been qualified upstream (privilege and type filtering happen elsewhere). A transfer arrives as a one-cycle strobe carrying a kind code, a source PC, a target PC and a metadata word, and the block stores these three fields as one record in a circular store of slots.

Software sets the active depth with a small code: the depth is sixteen records shifted left by that code, and the code saturates at a build-time maximum. A mode bit chooses between two behaviours. In plain circular logging every transfer is recorded and the oldest record gives way once the store is full. In call-stack emulation only calls are recorded, and a return removes the youngest call record. A clear strobe empties the whole store.

Software reaches the store through one indirect port addressed by a logical index. Index 0 is always the youngest record, index 1 the one before it, and so on. The port reads combinationally. A write strobe on the same port replaces the addressed record without moving the history.

Top module: `ctr_hist_top`

## Requirements
- R1: In circular mode (`stack_mode`=0) a strobe of any kind stores its record at the write position, which then advances, so the new record is read back at logical index 0. At most one record is taken per clock, and back-to-back strobes on consecutive clocks are all kept. Kind codes: call=0, return=1, jump=2, branch=3, trap=4, trap return=5.
- R2: Once the active depth is full, each new record replaces the oldest one. After N > depth records with depth D, index 0 holds record N-1 and index D-1 holds record N-D.
- R3: In stack mode (`stack_mode`=1) only kind 0 (call) adds a record. Kinds 2 to 5 change neither the contents nor the ordering.
- R4: Logical index i returns the i-th youngest record. An index that has never been written reads zero.
- R5: The active depth is 16 << `depth_code` (code 0 gives 16, code 1 gives 32).
- R6: After reset, and in the clock after a clear strobe, every index reads zero for source, target and metadata. A clear wins over a record strobe in the same clock.
- R7: A `depth_code` above `MAX_DCODE` acts as `MAX_DCODE`. With the default of 2 the depth is 64.
- R8: A logical index at or beyond the active depth reads as zero, and an indirect write to it changes nothing.
- R9: In stack mode a return (kind 1) with no record present changes neither the contents nor the index-to-record mapping.
- R10: An indirect write (`acc_we`=1) replaces only the record at `acc_idx` and leaves the ordering of all other records unchanged.
- R11: In stack mode a return (kind 1) removes the youngest record. The record that was at index 1 moves to index 0.
- R12: When a record strobe and an indirect write fall in the same clock, the write resolves its index against the history as it stood before that clock. The new record then lands at index 0, and the written record appears at the index it was written to plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid | input | 1 | Qualified transfer strobe |
| rec_kind | input | 3 | Transfer kind code |
| rec_src | input | 32 | Source PC of the transfer |
| rec_tgt | input | 32 | Target PC of the transfer |
| rec_meta | input | 16 | Metadata word of the transfer |
| depth_code | input | DCODE_W | Software depth select |
| stack_mode | input | 1 | 1 selects call-stack emulation |
| clr | input | 1 | Clear the whole history |
| acc_idx | input | IDX_W | Logical index for indirect read and write |
| acc_we | input | 1 | Indirect write strobe |
| acc_src | input | 32 | Source PC to write |
| acc_tgt | input | 32 | Target PC to write |
| acc_meta | input | 16 | Metadata to write |
| rd_src | output | 32 | Source PC at `acc_idx` |
| rd_tgt | output | 32 | Target PC at `acc_idx` |
| rd_meta | output | 16 | Metadata at `acc_idx` |

## Verification
A recorded transfer and an indirect write can land in the same clock, and the two fight over how a logical index maps to a slot. The bench fills three records, then raises a record strobe and a write to index 0 together. It expects the new record at index 0, the written value at index 1 and the older record at index 2. A clear raised together with a record strobe is also provoked, and the bench expects index 0 to read zero afterwards.

// File: rtl/ctr_hist_pkg.sv
package ctr_hist_pkg;

    localparam int PC_W       = 32;
    localparam int META_W     = 16;
    localparam int BASE_DEPTH = 16;

    typedef enum logic [2:0] {
        XK_CALL     = 3'd0,
        XK_RET      = 3'd1,
        XK_JUMP     = 3'd2,
        XK_BRANCH   = 3'd3,
        XK_TRAP     = 3'd4,
        XK_TRAP_RET = 3'd5
    } xfer_kind_e;

    typedef struct packed {
        logic [PC_W-1:0]   src;
        logic [PC_W-1:0]   tgt;
        logic [META_W-1:0] meta;
    } hist_rec_t;

    // Limit a software depth code to the largest code that is built.
    function automatic int unsigned sat_code(input int unsigned code, input int unsigned max_code);
        return (code > max_code) ? max_code : code;
    endfunction

endpackage

// File: rtl/ctr_hist_ptr.sv
module ctr_hist_ptr #(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic              pop_req,
    input  logic [SLOT_W-1:0] mask,
    input  logic [SLOT_W:0]   depth,
    output logic [SLOT_W-1:0] wp,
    output logic [SLOT_W:0]   fill,
    output logic              pop_go
);

    assign pop_go = pop_req && (fill != '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp   <= '0;
            fill <= '0;
        end else if (push) begin
            wp   <= (wp + 1'b1) & mask;
            fill <= (fill < depth) ? fill + 1'b1 : depth;
        end else if (pop_go) begin
            wp   <= (wp - 1'b1) & mask;
            fill <= fill - 1'b1;
        end
    end

endmodule

// File: rtl/ctr_hist_map.sv
module ctr_hist_map #(
    parameter int SLOT_W = 6,
    parameter int IDX_W  = 8
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [SLOT_W-1:0] wp,
    input  logic [SLOT_W-1:0] mask,
    input  logic [SLOT_W:0]   depth,
    output logic [SLOT_W-1:0] slot,
    output logic              in_range
);

    logic [IDX_W:0] idx_ext;
    logic [IDX_W:0] depth_ext;

    assign idx_ext   = {1'b0, idx};
    assign depth_ext = (IDX_W+1)'(depth);
    assign in_range  = idx_ext < depth_ext;
    // Youngest record sits one slot behind the write position.
    assign slot      = (wp - 1'b1 - idx[SLOT_W-1:0]) & mask;

endmodule

// File: rtl/ctr_hist_store.sv
module ctr_hist_store
    import ctr_hist_pkg::*;
#(
    parameter int SLOTS  = 64,
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              rec_we,
    input  logic [SLOT_W-1:0] rec_slot,
    input  hist_rec_t         rec_data,
    input  logic              pop_we,
    input  logic [SLOT_W-1:0] pop_slot,
    input  logic              acc_we,
    input  logic [SLOT_W-1:0] acc_slot,
    input  hist_rec_t         acc_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output hist_rec_t         rd_data
);

    hist_rec_t cells [SLOTS];

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        hist_rec_t cell_q;
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                cell_q <= '0;
            end else if (rec_we && rec_slot == SLOT_W'(k)) begin
                cell_q <= rec_data;
            end else if (pop_we && pop_slot == SLOT_W'(k)) begin
                cell_q <= '0;
            end else if (acc_we && acc_slot == SLOT_W'(k)) begin
                cell_q <= acc_data;
            end
        end
        assign cells[k] = cell_q;
    end

    assign rd_data = cells[rd_slot];

endmodule

// File: rtl/ctr_hist_top.sv
module ctr_hist_top
    import ctr_hist_pkg::*;
#(
    parameter int MAX_DCODE = 2,
    parameter int DCODE_W   = 4,
    parameter int IDX_W     = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rec_valid,
    input  logic [2:0]         rec_kind,
    input  logic [PC_W-1:0]    rec_src,
    input  logic [PC_W-1:0]    rec_tgt,
    input  logic [META_W-1:0]  rec_meta,
    input  logic [DCODE_W-1:0] depth_code,
    input  logic               stack_mode,
    input  logic               clr,
    input  logic [IDX_W-1:0]   acc_idx,
    input  logic               acc_we,
    input  logic [PC_W-1:0]    acc_src,
    input  logic [PC_W-1:0]    acc_tgt,
    input  logic [META_W-1:0]  acc_meta,
    output logic [PC_W-1:0]    rd_src,
    output logic [PC_W-1:0]    rd_tgt,
    output logic [META_W-1:0]  rd_meta
);

    localparam int SLOTS  = BASE_DEPTH << MAX_DCODE;
    localparam int SLOT_W = $clog2(SLOTS);

    xfer_kind_e        kind;
    logic [SLOT_W:0]   depth_val;
    logic [SLOT_W-1:0] mask;
    logic [SLOT_W-1:0] wp;
    logic [SLOT_W:0]   fill;
    logic              push, pop_req, pop_go;
    logic [SLOT_W-1:0] acc_slot, pop_slot;
    logic              acc_ok;
    hist_rec_t         rec_data, acc_data, rd_data;

    assign kind      = xfer_kind_e'(rec_kind);
    assign depth_val = (SLOT_W+1)'(BASE_DEPTH) << sat_code(32'(depth_code), MAX_DCODE);
    assign mask      = depth_val[SLOT_W-1:0] - 1'b1;

    assign push     = rec_valid && !clr && (!stack_mode || kind == XK_CALL);
    assign pop_req  = rec_valid && !clr && stack_mode && kind == XK_RET;
    assign pop_slot = (wp - 1'b1) & mask;

    assign rec_data = '{src: rec_src, tgt: rec_tgt, meta: rec_meta};
    assign acc_data = '{src: acc_src, tgt: acc_tgt, meta: acc_meta};

    ctr_hist_ptr #(.SLOT_W(SLOT_W)) ptr_i (
        .clk(clk), .rst(rst), .clr(clr), .push(push), .pop_req(pop_req),
        .mask(mask), .depth(depth_val), .wp(wp), .fill(fill), .pop_go(pop_go)
    );

    ctr_hist_map #(.SLOT_W(SLOT_W), .IDX_W(IDX_W)) map_i (
        .idx(acc_idx), .wp(wp), .mask(mask), .depth(depth_val),
        .slot(acc_slot), .in_range(acc_ok)
    );

    ctr_hist_store #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) store_i (
        .clk(clk), .rst(rst), .clr(clr),
        .rec_we(push), .rec_slot(wp), .rec_data(rec_data),
        .pop_we(pop_go), .pop_slot(pop_slot),
        .acc_we(acc_we && acc_ok), .acc_slot(acc_slot), .acc_data(acc_data),
        .rd_slot(acc_slot), .rd_data(rd_data)
    );

    assign rd_src  = acc_ok ? rd_data.src  : '0;
    assign rd_tgt  = acc_ok ? rd_data.tgt  : '0;
    assign rd_meta = acc_ok ? rd_data.meta : '0;

endmodule

// File: rtl/ctr_hist_chk.sv
module ctr_hist_chk #(
    parameter int SLOT_W = 6,
    parameter int IDX_W  = 8,
    parameter int PC_W   = 32,
    parameter int META_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              rec_valid,
    input logic [2:0]        rec_kind,
    input logic              stack_mode,
    input logic              clr,
    input logic              acc_we,
    input logic [IDX_W-1:0]  acc_idx,
    input logic [SLOT_W-1:0] wp,
    input logic [SLOT_W:0]   fill,
    input logic [SLOT_W:0]   depth_val,
    input logic [PC_W-1:0]   rd_src,
    input logic [PC_W-1:0]   rd_tgt,
    input logic [META_W-1:0] rd_meta
);

    a_r1_record_fills: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !stack_mode && !clr) |=> (fill != '0));

    a_r3_stack_ignores: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && stack_mode && !clr && rec_kind > 3'd1) |=> ($stable(wp) && $stable(fill)));

    a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        clr |=> (fill == '0 && rd_src == '0 && rd_tgt == '0 && rd_meta == '0));

    a_r8_oob_reads_zero: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, acc_idx} >= (IDX_W+1)'(depth_val)) |-> (rd_src == '0 && rd_tgt == '0 && rd_meta == '0));

    a_r9_empty_pop_still: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && stack_mode && !clr && rec_kind == 3'd1 && fill == '0) |=> ($stable(wp) && fill == '0));

    a_r10_write_keeps_order: assert property (@(posedge clk) disable iff (rst)
        (acc_we && !rec_valid && !clr) |=> ($stable(wp) && $stable(fill)));

endmodule

bind ctr_hist_top ctr_hist_chk #(
    .SLOT_W(SLOT_W), .IDX_W(IDX_W), .PC_W(ctr_hist_pkg::PC_W), .META_W(ctr_hist_pkg::META_W)
) chk_i (
    .clk(clk), .rst(rst), .rec_valid(rec_valid), .rec_kind(rec_kind),
    .stack_mode(stack_mode), .clr(clr), .acc_we(acc_we), .acc_idx(acc_idx),
    .wp(wp), .fill(fill), .depth_val(depth_val),
    .rd_src(rd_src), .rd_tgt(rd_tgt), .rd_meta(rd_meta)
);

// File: tb/ctr_hist_tb.sv
module ctr_hist_top_tb_top;
    import ctr_hist_pkg::*;

    localparam int CLK_P = 10;
    localparam int NVEC  = 21;

    localparam logic [2:0] OP_NOP = 3'd0, OP_REC = 3'd1, OP_WR = 3'd2, OP_CLR = 3'd3;

    typedef struct packed {
        logic [2:0]  op;
        logic [2:0]  kind;
        logic        mode;
        logic [7:0]  idx;
        logic [15:0] seed;
        logic [7:0]  chk;
        logic [15:0] exp;
        logic [3:0]  rq;
    } vec_t;

    // op, kind, mode, idx, seed, check index, expected seed (0 = all zero), requirement
    localparam vec_t VECS [NVEC] = '{
        '{OP_REC, 3'd3, 1'b0, 8'd0,  16'h0001, 8'd0,  16'h0001, 4'd1},  // R1 branch recorded
        '{OP_REC, 3'd2, 1'b0, 8'd0,  16'h0002, 8'd0,  16'h0002, 4'd4},  // R4 youngest
        '{OP_REC, 3'd4, 1'b0, 8'd0,  16'h0003, 8'd1,  16'h0002, 4'd4},  // R4 next youngest
        '{OP_NOP, 3'd0, 1'b0, 8'd0,  16'h0000, 8'd2,  16'h0001, 4'd4},  // R4 oldest
        '{OP_NOP, 3'd0, 1'b0, 8'd0,  16'h0000, 8'd3,  16'h0000, 4'd4},  // R4 unwritten
        '{OP_WR,  3'd0, 1'b0, 8'd1,  16'h0077, 8'd1,  16'h0077, 4'd10}, // R10 write lands
        '{OP_NOP, 3'd0, 1'b0, 8'd0,  16'h0000, 8'd0,  16'h0003, 4'd10}, // R10 others kept
        '{OP_WR,  3'd0, 1'b0, 8'd16, 16'h0055, 8'd16, 16'h0000, 4'd8},  // R8 oob write
        '{OP_NOP, 3'd0, 1'b0, 8'd0,  16'h0000, 8'd2,  16'h0001, 4'd8},  // R8 no alias
        '{OP_CLR, 3'd0, 1'b0, 8'd0,  16'h0000, 8'd0,  16'h0000, 4'd6},  // R6 clear
        '{OP_NOP, 3'd0, 1'b0, 8'd0,  16'h0000, 8'd2,  16'h0000, 4'd6},  // R6 clear deep
        '{OP_REC, 3'd0, 1'b1, 8'd0,  16'h0010, 8'd0,  16'h0010, 4'd3},  // R3 call kept
        '{OP_REC, 3'd3, 1'b1, 8'd0,  16'h0011, 8'd0,  16'h0010, 4'd3},  // R3 branch ignored
        '{OP_REC, 3'd0, 1'b1, 8'd0,  16'h0012, 8'd0,  16'h0012, 4'd3},  // R3 call kept
        '{OP_REC, 3'd1, 1'b1, 8'd0,  16'h0013, 8'd0,  16'h0010, 4'd11}, // R11 pop
        '{OP_NOP, 3'd0, 1'b1, 8'd0,  16'h0000, 8'd1,  16'h0000, 4'd11}, // R11 popped gone
        '{OP_REC, 3'd1, 1'b1, 8'd0,  16'h0014, 8'd0,  16'h0000, 4'd11}, // R11 pop last
        '{OP_WR,  3'd0, 1'b1, 8'd3,  16'h0020, 8'd3,  16'h0020, 4'd10}, // R10 write in stack mode
        '{OP_REC, 3'd1, 1'b1, 8'd0,  16'h0015, 8'd3,  16'h0020, 4'd9},  // R9 empty pop
        '{OP_REC, 3'd0, 1'b1, 8'd0,  16'h0016, 8'd0,  16'h0016, 4'd9},  // R9 push after
        '{OP_NOP, 3'd0, 1'b1, 8'd0,  16'h0000, 8'd4,  16'h0020, 4'd9}   // R9 mapping kept
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rec_valid = 1'b0;
    logic [2:0]        rec_kind = '0;
    logic [PC_W-1:0]   rec_src = '0, rec_tgt = '0;
    logic [META_W-1:0] rec_meta = '0;
    logic [3:0]        depth_code = '0;
    logic              stack_mode = 1'b0;
    logic              clr = 1'b0;
    logic [7:0]        acc_idx = '0;
    logic              acc_we = 1'b0;
    logic [PC_W-1:0]   acc_src = '0, acc_tgt = '0;
    logic [META_W-1:0] acc_meta = '0;
    logic [PC_W-1:0]   rd_src, rd_tgt;
    logic [META_W-1:0] rd_meta;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    ctr_hist_top dut_i (
        .clk(clk), .rst(rst), .rec_valid(rec_valid), .rec_kind(rec_kind),
        .rec_src(rec_src), .rec_tgt(rec_tgt), .rec_meta(rec_meta),
        .depth_code(depth_code), .stack_mode(stack_mode), .clr(clr),
        .acc_idx(acc_idx), .acc_we(acc_we), .acc_src(acc_src), .acc_tgt(acc_tgt),
        .acc_meta(acc_meta), .rd_src(rd_src), .rd_tgt(rd_tgt), .rd_meta(rd_meta)
    );

    task automatic idle_inputs();
        rec_valid = 1'b0;
        acc_we    = 1'b0;
        clr       = 1'b0;
    endtask

    // Read logical index idx and compare with the record built from seed.
    task automatic check_idx(input logic [7:0] idx, input logic [15:0] seed, input string tag);
        logic [PC_W-1:0]   e_src, e_tgt;
        logic [META_W-1:0] e_meta;
        idle_inputs();
        acc_idx = idx;
        #1;
        e_src  = (seed == 0) ? '0 : {16'hA000, seed};
        e_tgt  = (seed == 0) ? '0 : {16'hB000, seed};
        e_meta = seed;
        checks++;
        if (rd_src !== e_src || rd_tgt !== e_tgt || rd_meta !== e_meta) begin
            errors++;
            $display("FAIL %s idx %0d: got %h/%h/%h expected %h/%h/%h",
                     tag, idx, rd_src, rd_tgt, rd_meta, e_src, e_tgt, e_meta);
        end
    endtask

    task automatic set_rec(input logic [2:0] kind, input logic [15:0] seed);
        rec_valid = 1'b1;
        rec_kind  = kind;
        rec_src   = {16'hA000, seed};
        rec_tgt   = {16'hB000, seed};
        rec_meta  = seed;
    endtask

    task automatic set_wr(input logic [7:0] idx, input logic [15:0] seed);
        acc_we   = 1'b1;
        acc_idx  = idx;
        acc_src  = {16'hA000, seed};
        acc_tgt  = {16'hB000, seed};
        acc_meta = seed;
    endtask

    task automatic clear_once();
        @(negedge clk);
        idle_inputs();
        clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    // Back-to-back branch records on consecutive clocks, seeds base+k.
    task automatic burst(input int n, input logic [15:0] base);
        @(negedge clk);
        for (int k = 0; k < n; k++) begin
            set_rec(3'd3, base + 16'(k));
            @(posedge clk);
            @(negedge clk);
        end
        idle_inputs();
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idx(8'd0, 16'h0, "R6 reset");
        check_idx(8'd5, 16'h0, "R6 reset");
        rst = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            idle_inputs();
            stack_mode = VECS[v].mode;
            case (VECS[v].op)
                OP_REC:  set_rec(VECS[v].kind, VECS[v].seed);
                OP_WR:   set_wr(VECS[v].idx, VECS[v].seed);
                OP_CLR:  clr = 1'b1;
                default: ;
            endcase
            @(posedge clk);
            @(negedge clk);
            check_idx(VECS[v].chk, VECS[v].exp, $sformatf("R%0d vec %0d", VECS[v].rq, v));
        end

        // R2 wrap at depth 16
        stack_mode = 1'b0;
        depth_code = 4'd0;
        clear_once();
        burst(20, 16'h0100);
        check_idx(8'd0,  16'h0113, "R2 youngest after wrap");
        check_idx(8'd15, 16'h0104, "R2 oldest kept");
        check_idx(8'd16, 16'h0000, "R8 beyond depth");

        // R5 depth code 1 gives 32
        depth_code = 4'd1;
        clear_once();
        burst(40, 16'h0100);
        check_idx(8'd31, 16'h0108, "R5 depth 32 oldest");
        check_idx(8'd32, 16'h0000, "R5 depth 32 limit");

        // R7 code 9 saturates to depth 64
        depth_code = 4'd9;
        clear_once();
        burst(20, 16'h0100);
        check_idx(8'd19, 16'h0100, "R7 saturated first");
        check_idx(8'd16, 16'h0103, "R7 beyond 16");
        check_idx(8'd63, 16'h0000, "R7 unfilled top");
        check_idx(8'd64, 16'h0000, "R8 beyond 64");

        // R12 record and indirect write in one clock
        depth_code = 4'd0;
        clear_once();
        burst(3, 16'h0001);
        @(negedge clk);
        set_rec(3'd2, 16'h0004);
        set_wr(8'd0, 16'h0099);
        @(posedge clk);
        @(negedge clk);
        check_idx(8'd0, 16'h0004, "R12 record at 0");
        check_idx(8'd1, 16'h0099, "R12 write shifted");
        check_idx(8'd2, 16'h0002, "R12 older kept");

        // R6 clear beats a record in the same clock
        @(negedge clk);
        set_rec(3'd3, 16'h0005);
        clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_idx(8'd0, 16'h0000, "R6 clear wins");
        check_idx(8'd1, 16'h0000, "R6 clear wins deep");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule